// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block sits between an asynchronous, EPROM-style parallel memory bus and the synchronous logic of a flash controller. The bus master drives active-low chip-enable, output-enable and write-enable pins, an active-low reset pin, an address bus and a data bus. None of these is related to the system clock. The block passes every pin through a chain of synchroniser flops and compares each sample with the one before it to find the edges. From those edges it derives three things: the output enable for the data bus, a read strobe that carries the address being read, and write-command events.

A write cycle can be strobed by either chip-enable or write-enable. The address belongs to the moment when the second of the two goes low, and the data belongs to the moment when the first of the two goes high. When both pins change in the same sample, the block treats that as one edge. Each write event is a single-cycle pulse that carries the latched address and data. A command decoder further downstream consumes these events.

A low level on the reset pin floats the data bus and cancels any write that is in progress. When the pin returns high, the bus goes back to the read or idle state that the control pins call for.

Top module: `pflash_bus_front`

## Requirements
- R1: Every bus pin passes through SYNC_STAGES synchroniser flops. An output that depends on a pin change shows that change on the (SYNC_STAGES+1)-th rising clock edge after the change, and not earlier.
- R2: `dq_oe` is 1 only while chip-enable is low, output-enable is low, write-enable is high and the reset pin is high. It is 0 whenever chip-enable or output-enable is high.
- R3: `rd_strobe` pulses for one cycle, with the current address on `rd_addr`, when a read becomes active. It pulses again each time the sampled address changes while the read stays active.
- R4: The write address is captured in the sample where chip-enable and write-enable first become low together, provided output-enable is high. Later address changes in the same write cycle are ignored.
- R5: `wr_valid` pulses for exactly one cycle in the sample where the first of chip-enable or write-enable returns high. `wr_data` then holds the data bus value sampled in the cycle just before that rise, and `wr_addr` holds the address captured under R4.
- R6: Either pin can be the strobe. A write framed by write-enable with chip-enable held low, and a write framed by chip-enable with write-enable held low, both produce an event. A fall or a rise of both pins in the same sample counts as one edge.
- R7: If output-enable is low when the strobe window opens, or goes low at any point before it closes, no write event is produced.
- R8: While the reset pin is low, `dq_oe` is 0, no `rd_strobe` or `wr_valid` is produced, and a write cycle in progress is abandoned. The abandoned cycle produces no event even after its closing edge.
- R9: When the reset pin returns high while chip-enable and output-enable are low and write-enable is high, the read resumes. `dq_oe` returns to 1 and `rd_strobe` fires with the current address.
- R10: The synchronous reset `rst` clears all outputs to 0. `wr_addr` and `wr_data` keep their values from one write event to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_ce_n | input | 1 | Bus chip-enable, active low, asynchronous |
| pin_oe_n | input | 1 | Bus output-enable, active low, asynchronous |
| pin_we_n | input | 1 | Bus write-enable, active low, asynchronous |
| pin_rst_n | input | 1 | Bus reset, active low, asynchronous |
| pin_addr | input | ADDR_W | Bus address |
| pin_dq_in | input | DATA_W | Data bus as driven by the master |
| dq_oe | output | 1 | Enable for the data bus output drivers |
| rd_strobe | output | 1 | One-cycle pulse: a read of `rd_addr` has started |
| rd_addr | output | ADDR_W | Address of the current read |
| wr_valid | output | 1 | One-cycle pulse: a write command has been latched |
| wr_addr | output | ADDR_W | Address of the last write command |
| wr_data | output | DATA_W | Data of the last write command |

## Verification
The bench builds the block with a 17-bit address, an 8-bit data bus and three synchroniser stages instead of the default two. The extra stage makes the latency check in R1 depend on the parameter rather than on a fixed count. The bench drives write cycles framed by write-enable, by chip-enable and by both pins at once. It changes the address after the capture point and the data after the first rise, so that a block latching on the wrong edge gives the wrong values. Output-enable and reset-pin disturbances are placed inside open write windows and inside active reads, where a missing cancel shows up as an event the scoreboard did not expect.

// File: rtl/pflash_bus_pkg.sv
package pflash_bus_pkg;

    // Sampled control pins, all active low
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic rst_n;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Idle bus: every control pin inactive (high)
    localparam logic [CTRL_W-1:0] CTRL_IDLE = '1;

    typedef enum logic [0:0] {
        WR_IDLE  = 1'b0,
        WR_ARMED = 1'b1
    } wr_state_t;

    // A read is being requested on the bus
    function automatic logic is_read(input ctrl_t c);
        return !c.ce_n && !c.oe_n && c.we_n && c.rst_n;
    endfunction

    // Both strobe pins are low: the write window is open
    function automatic logic strobe_window(input ctrl_t c);
        return !c.ce_n && !c.we_n;
    endfunction

endpackage

// File: rtl/pfb_sync.sv
module pfb_sync #(
    parameter int              W      = 1,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    INIT   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pfb_read_ctrl.sv
module pfb_read_ctrl
    import pflash_bus_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             cur_ctrl,
    input  ctrl_t             prev_ctrl,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] prev_addr,
    output logic              dq_oe,
    output logic              rd_strobe,
    output logic [ADDR_W-1:0] rd_addr
);
    logic act_now, act_prev, addr_moved, start_rd;

    always_comb begin
        act_now    = is_read(cur_ctrl);
        act_prev   = is_read(prev_ctrl);
        addr_moved = (cur_addr != prev_addr);
        start_rd   = act_now && (!act_prev || addr_moved);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_oe     <= 1'b0;
            rd_strobe <= 1'b0;
            rd_addr   <= '0;
        end else begin
            dq_oe     <= act_now;
            rd_strobe <= start_rd;
            if (start_rd) rd_addr <= cur_addr;
        end
    end
endmodule

// File: rtl/pfb_write_capture.sv
module pfb_write_capture
    import pflash_bus_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             cur_ctrl,
    input  logic              prev_window,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] prev_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    wr_state_t         state;
    logic [ADDR_W-1:0] held_addr;
    logic              win_now, win_open, win_close;

    always_comb begin
        win_now   = strobe_window(cur_ctrl);
        win_open  = win_now && !prev_window;   // later falling edge
        win_close = !win_now && prev_window;   // first rising edge
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WR_IDLE;
            held_addr <= '0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (!cur_ctrl.rst_n) begin
                state <= WR_IDLE;
            end else begin
                unique case (state)
                    WR_IDLE: begin
                        if (win_open && cur_ctrl.oe_n) begin
                            state     <= WR_ARMED;
                            held_addr <= cur_addr;
                        end
                    end
                    WR_ARMED: begin
                        if (!cur_ctrl.oe_n) begin
                            state <= WR_IDLE;
                        end else if (win_close) begin
                            state    <= WR_IDLE;
                            wr_valid <= 1'b1;
                            wr_addr  <= held_addr;
                            wr_data  <= prev_data;
                        end
                    end
                    default: state <= WR_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/pflash_bus_front.sv
module pflash_bus_front
    import pflash_bus_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_ce_n,
    input  logic              pin_oe_n,
    input  logic              pin_we_n,
    input  logic              pin_rst_n,
    input  logic [ADDR_W-1:0] pin_addr,
    input  logic [DATA_W-1:0] pin_dq_in,
    output logic              dq_oe,
    output logic              rd_strobe,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int BUS_W = ADDR_W + DATA_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic [BUS_W-1:0]  bus_q;
    ctrl_t             cur_ctrl, prev_ctrl;
    logic [ADDR_W-1:0] cur_addr, prev_addr;
    logic [DATA_W-1:0] cur_data, prev_data;

    pfb_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .INIT(CTRL_IDLE)) u_ctrl_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pin_ce_n, pin_oe_n, pin_we_n, pin_rst_n}),
        .q   (ctrl_q)
    );

    pfb_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .INIT('0)) u_bus_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pin_addr, pin_dq_in}),
        .q   (bus_q)
    );

    always_comb begin
        cur_ctrl = ctrl_t'(ctrl_q);
        cur_addr = bus_q[BUS_W-1:DATA_W];
        cur_data = bus_q[DATA_W-1:0];
    end

    // One-sample history for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ctrl <= ctrl_t'(CTRL_IDLE);
            prev_addr <= '0;
            prev_data <= '0;
        end else begin
            prev_ctrl <= cur_ctrl;
            prev_addr <= cur_addr;
            prev_data <= cur_data;
        end
    end

    pfb_read_ctrl #(.ADDR_W(ADDR_W)) u_read (
        .clk       (clk),
        .rst       (rst),
        .cur_ctrl  (cur_ctrl),
        .prev_ctrl (prev_ctrl),
        .cur_addr  (cur_addr),
        .prev_addr (prev_addr),
        .dq_oe     (dq_oe),
        .rd_strobe (rd_strobe),
        .rd_addr   (rd_addr)
    );

    pfb_write_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_write (
        .clk         (clk),
        .rst         (rst),
        .cur_ctrl    (cur_ctrl),
        .prev_window (strobe_window(prev_ctrl)),
        .cur_addr    (cur_addr),
        .prev_data   (prev_data),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data)
    );
endmodule

// File: rtl/pflash_bus_front_chk.sv
module pflash_bus_front_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              s_ce_n,
    input logic              s_oe_n,
    input logic              s_rst_n,
    input logic              dq_oe,
    input logic              rd_strobe,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data
);
    // R2
    float_when_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        (s_ce_n || s_oe_n) |=> !dq_oe);

    // R3
    strobe_only_while_driving_chk: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> dq_oe);

    // R5
    write_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R5
    no_write_while_driving_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !dq_oe);

    // R7
    write_needs_oe_high_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(s_oe_n));

    // R8
    reset_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !s_rst_n |=> (!dq_oe && !wr_valid && !rd_strobe));

    // R10
    write_fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> ($stable(wr_addr) && $stable(wr_data)));
endmodule

bind pflash_bus_front pflash_bus_front_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .s_ce_n    (cur_ctrl.ce_n),
    .s_oe_n    (cur_ctrl.oe_n),
    .s_rst_n   (cur_ctrl.rst_n),
    .dq_oe     (dq_oe),
    .rd_strobe (rd_strobe),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
);

// File: tb/pflash_bus_front_test.sv
module pflash_bus_front_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 17;
    localparam int DW   = 8;
    localparam int SYNC = 3;
    localparam int SETTLE = SYNC + 3;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } wr_item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, prst_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          dq_oe, rd_strobe, wr_valid;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int errors = 0;
    wr_item_t      wr_q[$];
    logic [AW-1:0] rd_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pflash_bus_front #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SYNC)) uut (
        .clk (clk), .rst (rst),
        .pin_ce_n (ce_n), .pin_oe_n (oe_n), .pin_we_n (we_n), .pin_rst_n (prst_n),
        .pin_addr (addr), .pin_dq_in (din),
        .dq_oe (dq_oe), .rd_strobe (rd_strobe), .rd_addr (rd_addr),
        .wr_valid (wr_valid), .wr_addr (wr_addr), .wr_data (wr_data)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected items as the design produces them
    always begin
        @(posedge clk);
        #1;
        if (!rst && wr_valid) begin
            if (wr_q.size() == 0) check("R5/R7/R8 unexpected write event", 1, 0);
            else begin
                wr_item_t e;
                e = wr_q.pop_front();
                check("R4 write address", 32'(wr_addr), 32'(e.a));
                check("R5 write data", 32'(wr_data), 32'(e.d));
            end
        end
        if (!rst && rd_strobe) begin
            if (rd_q.size() == 0) check("R3/R8 unexpected read strobe", 1, 0);
            else begin
                logic [AW-1:0] ea;
                ea = rd_q.pop_front();
                check("R3 read address", 32'(rd_addr), 32'(ea));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_cycles(4);
        rst = 1'b0;
        wait_cycles(2);
        // R10 reset state
        check("R10 dq_oe after reset", 32'(dq_oe), 0);
        check("R10 wr_valid after reset", 32'(wr_valid), 0);
        check("R10 wr_addr after reset", 32'(wr_addr), 0);

        // R1/R2/R3: read start and latency
        addr = 17'h1A5A5;
        rd_q.push_back(17'h1A5A5);
        ce_n = 1'b0; oe_n = 1'b0;
        repeat (SYNC) @(posedge clk);
        #1 check("R1 dq_oe not before latency", 32'(dq_oe), 0);
        @(posedge clk);
        #1 check("R1 dq_oe at latency", 32'(dq_oe), 1);
        wait_cycles(SETTLE);
        rd_q.push_back(17'h00FF0);
        addr = 17'h00FF0;
        wait_cycles(SETTLE);
        check("R2 dq_oe during read", 32'(dq_oe), 1);
        oe_n = 1'b1;
        wait_cycles(SETTLE);
        check("R2 dq_oe with oe high", 32'(dq_oe), 0);
        oe_n = 1'b0; ce_n = 1'b1;
        wait_cycles(SETTLE);
        check("R2 dq_oe with ce high", 32'(dq_oe), 0);
        oe_n = 1'b1;
        wait_cycles(SETTLE);

        // R4/R5: write framed by write-enable, address moves after capture
        ce_n = 1'b0;
        wait_cycles(SETTLE);
        addr = 17'h12345; din = 8'h3C; we_n = 1'b0;
        wait_cycles(SETTLE);
        addr = 17'h00001;
        wait_cycles(SETTLE);
        wr_q.push_back('{a: 17'h12345, d: 8'h3C});
        we_n = 1'b1;
        wait_cycles(SETTLE);
        din = 8'hFF; ce_n = 1'b1;
        wait_cycles(SETTLE);
        check("R10 wr_addr held", 32'(wr_addr), 32'h12345);

        // R6: write framed by chip-enable
        we_n = 1'b0;
        wait_cycles(SETTLE);
        addr = 17'h0ABCD; din = 8'h5A; ce_n = 1'b0;
        wait_cycles(SETTLE);
        wr_q.push_back('{a: 17'h0ABCD, d: 8'h5A});
        ce_n = 1'b1;
        wait_cycles(SETTLE);
        we_n = 1'b1;
        wait_cycles(SETTLE);

        // R5/R6: simultaneous fall, data changes after first rise
        addr = 17'h1FFFF; din = 8'h81; ce_n = 1'b0; we_n = 1'b0;
        wait_cycles(SETTLE);
        wr_q.push_back('{a: 17'h1FFFF, d: 8'h81});
        we_n = 1'b1;
        wait_cycles(SETTLE);
        din = 8'h00;
        wait_cycles(SETTLE);
        ce_n = 1'b1;
        wait_cycles(SETTLE);

        // R6: simultaneous fall and simultaneous rise
        addr = 17'h00100; din = 8'h42; ce_n = 1'b0; we_n = 1'b0;
        wait_cycles(SETTLE);
        wr_q.push_back('{a: 17'h00100, d: 8'h42});
        ce_n = 1'b1; we_n = 1'b1;
        wait_cycles(SETTLE);

        // R7: output-enable low when window opens
        we_n = 1'b0; oe_n = 1'b0;
        wait_cycles(SETTLE);
        addr = 17'h02222; din = 8'h11; ce_n = 1'b0;
        wait_cycles(SETTLE);
        ce_n = 1'b1;
        wait_cycles(SETTLE);
        oe_n = 1'b1;
        wait_cycles(SETTLE);
        we_n = 1'b1;
        wait_cycles(SETTLE);
        // R7: output-enable pulsed low inside an open window
        addr = 17'h03333; din = 8'h22; ce_n = 1'b0; we_n = 1'b0;
        wait_cycles(SETTLE);
        oe_n = 1'b0;
        wait_cycles(SETTLE);
        oe_n = 1'b1;
        wait_cycles(SETTLE);
        we_n = 1'b1;
        wait_cycles(SETTLE);
        ce_n = 1'b1;
        wait_cycles(SETTLE);
        check("R7 wr_addr unchanged", 32'(wr_addr), 32'h00100);

        // R8/R9: reset pin during a read
        addr = 17'h0F0F0;
        rd_q.push_back(17'h0F0F0);
        ce_n = 1'b0; oe_n = 1'b0;
        wait_cycles(SETTLE);
        check("R2 dq_oe read before reset pin", 32'(dq_oe), 1);
        prst_n = 1'b0;
        wait_cycles(SETTLE);
        check("R8 dq_oe with reset pin low", 32'(dq_oe), 0);
        rd_q.push_back(17'h0F0F0);
        prst_n = 1'b1;
        wait_cycles(SETTLE);
        check("R9 dq_oe after reset pin release", 32'(dq_oe), 1);
        ce_n = 1'b1; oe_n = 1'b1;
        wait_cycles(SETTLE);

        // R8: write abandoned by reset pin
        addr = 17'h11111; din = 8'h99; ce_n = 1'b0; we_n = 1'b0;
        wait_cycles(SETTLE);
        prst_n = 1'b0;
        wait_cycles(SETTLE);
        ce_n = 1'b1; we_n = 1'b1;
        wait_cycles(SETTLE);
        prst_n = 1'b1;
        wait_cycles(SETTLE);
        check("R8 wr_addr after abandoned write", 32'(wr_addr), 32'h00100);
        check("R8 wr_data after abandoned write", 32'(wr_data), 32'h42);

        wait_cycles(SETTLE);
        check("R5 all expected writes seen", 32'(wr_q.size()), 0);
        check("R3 all expected reads seen", 32'(rd_q.size()), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule